// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory array from the digital side. Three comparator flags arrive asynchronously. One says the supply is above the write-protect trip level. One says it is above the higher full-function level. One says it is above the battery switchover level. The block synchronizes and debounces each flag, then runs a five-state sequencer that decides three things: whether the array may be accessed, whether its outputs must float, and whether the battery feeds the array.

The host chip-enable and write-enable pass through a gate before they reach the array. The gate closes in the same clock edge in which protection is decided, so a write strobe that is in progress is cut off and never reaches the array as a partial write.

The battery starts electrically isolated so that it keeps its full capacity. The first time the supply climbs past the trip level, a one-time seal breaks and battery backup is armed for good. After power returns, accesses stay blocked for a recovery interval counted in millisecond ticks. The gate then opens only once the host has released chip-enable.

Top module: `pwr_guard_top`

## Requirements
- R1: After reset the block is sealed: writeInhibit=1, outHiZ=1, battSel=0, battArmed=0, arrayCeN=1, arrayWeN=1.
- R2: A flag change that is held for at least two clocks takes effect. A flag pulse one clock wide has no effect. A held change reaches the outputs four clock edges after it is first sampled (two synchronizer stages, one stability stage, one state stage).
- R3: battArmed stays 0 until the trip flag is first seen high. After that it stays 1 until reset. While sealed, battSel is 0 whatever the switchover flag says.
- R4: Whenever writeInhibit=1, arrayCeN=1, arrayWeN=1 and outHiZ=1, whatever the host inputs are.
- R5: When protection asserts during a host write (hostWeN=0), arrayWeN goes to 1 in the same cycle in which writeInhibit goes to 1.
- R6: Once armed, battSel=1 while the filtered switchover flag is low. battSel returns to 0 when that flag is high again, and the block stays protected.
- R7: Protection ends only when the full-function flag is high. A supply above the trip level but below the full-function level keeps writeInhibit=1.
- R8: After the full-function flag is seen, writeInhibit stays 1 until RECOVER_TICKS msTick pulses have been counted.
- R9: When recovery ends, the gate opens (outHiZ=0) only at a clock edge at which hostCeN=1. While the host holds hostCeN=0, the gate stays closed.
- R10: While the gate is open, arrayCeN follows hostCeN and arrayWeN follows hostWeN in the same cycle, with no register in between.
- R11: If the trip flag falls during recovery, the block returns to protection. The tick count restarts from zero on the next recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msTick | input | 1 | One-clock pulse once per millisecond |
| aboveTrip | input | 1 | Asynchronous flag: supply above the write-protect trip level |
| aboveFull | input | 1 | Asynchronous flag: supply above the full-function level |
| aboveSwitch | input | 1 | Asynchronous flag: supply above the battery switchover level |
| hostCeN | input | 1 | Host chip-enable, active low |
| hostWeN | input | 1 | Host write-enable, active low |
| arrayCeN | output | 1 | Gated chip-enable to the array, active low |
| arrayWeN | output | 1 | Gated write-enable to the array, active low |
| writeInhibit | output | 1 | High while writes are blocked |
| outHiZ | output | 1 | High while the array data outputs must float |
| battSel | output | 1 | High while the battery feeds the array |
| battArmed | output | 1 | High once the freshness seal is broken |

## Verification
The assertions check, on every cycle, the relations between outputs that must always hold:
- blocking forces both strobes high and the outputs to float;
- the battery is never selected before the seal breaks or while access is allowed;
- the seal, once broken, never re-forms;
- the gate opens only after an edge with chip-enable released.

Only the bench scenarios can show the timing-dependent behaviour: the four-edge flag latency, the rejection of one-clock glitches, the hysteresis between the trip and full-function levels, the length of the tick-counted recovery, and its restart when power drops during recovery. A cycle-accurate reference model covers these on every clock.

// File: rtl/pwr_guard_pkg.sv
`timescale 1ns/1ps
package pwr_guard_pkg;

  // Bit positions of the comparator flag vector
  localparam int FLAG_W      = 3;
  localparam int FLAG_TRIP   = 0;
  localparam int FLAG_FULL   = 1;
  localparam int FLAG_SWITCH = 2;

  typedef enum logic [2:0] {
    ST_SEALED     = 3'd0,
    ST_POWERED_OK = 3'd1,
    ST_PROTECTED  = 3'd2,
    ST_BATTERY    = 3'd3,
    ST_RECOVERING = 3'd4
  } guardState_t;

  // Strobes from control to datapath, valid for the coming edge
  typedef struct packed {
    logic allowAccess;  // next state permits array access
    logic useBattery;   // next state runs from battery
    logic breakSeal;    // first qualified rise above trip level
  } guardStrobe_t;

endpackage

// File: rtl/pwr_guard_sync.sv
`timescale 1ns/1ps
module pwr_guard_sync #(
  parameter int WIDTH       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CLKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawFlags,
  output logic [WIDTH-1:0] filtFlags
);

  localparam int CHAIN = SYNC_STAGES + STABLE_CLKS - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_flag
    logic [CHAIN-1:0]       chainQ;
    logic [STABLE_CLKS-1:0] window;
    logic                   allSame;
    logic                   filtQ;

    assign window  = chainQ[CHAIN-1 -: STABLE_CLKS];
    assign allSame = (&window) | ~(|window);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chainQ <= '0;
        filtQ  <= 1'b0;
      end else begin
        chainQ <= {chainQ[CHAIN-2:0], rawFlags[b]};
        if (allSame) filtQ <= chainQ[CHAIN-1];
      end
    end

    assign filtFlags[b] = filtQ;
  end

endmodule

// File: rtl/pwr_guard_ctrl.sv
`timescale 1ns/1ps
module pwr_guard_ctrl
  import pwr_guard_pkg::*;
#(
  parameter int RECOVER_TICKS = 125
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] flags,
  input  logic              msTick,
  output guardStrobe_t      strobe
);

  localparam int CNT_W = $clog2(RECOVER_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOVER_TICKS);

  guardState_t     stateQ, stateNext;
  logic [CNT_W-1:0] tickCntQ;
  logic            tripOk, fullOk, switchOk, recoverDone;

  assign tripOk      = flags[FLAG_TRIP];
  assign fullOk      = flags[FLAG_FULL];
  assign switchOk    = flags[FLAG_SWITCH];
  assign recoverDone = (tickCntQ == CNT_LAST);

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_SEALED: begin
        if (tripOk) stateNext = ST_RECOVERING;
      end
      ST_POWERED_OK: begin
        if (!switchOk)    stateNext = ST_BATTERY;
        else if (!tripOk) stateNext = ST_PROTECTED;
      end
      ST_PROTECTED: begin
        if (!switchOk)             stateNext = ST_BATTERY;
        else if (tripOk && fullOk) stateNext = ST_RECOVERING;
      end
      ST_BATTERY: begin
        if (switchOk) stateNext = ST_PROTECTED;
      end
      ST_RECOVERING: begin
        if (!switchOk)                  stateNext = ST_BATTERY;
        else if (!tripOk)               stateNext = ST_PROTECTED;
        else if (recoverDone && fullOk) stateNext = ST_POWERED_OK;
      end
      default: stateNext = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_SEALED;
      tickCntQ <= '0;
    end else begin
      stateQ <= stateNext;
      if (stateQ != ST_RECOVERING || stateNext != ST_RECOVERING)
        tickCntQ <= '0;
      else if (msTick && !recoverDone)
        tickCntQ <= tickCntQ + 1'b1;
    end
  end

  always_comb begin
    strobe.allowAccess = (stateNext == ST_POWERED_OK);
    strobe.useBattery  = (stateNext == ST_BATTERY);
    strobe.breakSeal   = (stateQ == ST_SEALED) && tripOk;
  end

endmodule

// File: rtl/pwr_guard_dp.sv
`timescale 1ns/1ps
module pwr_guard_dp
  import pwr_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  guardStrobe_t strobe,
  input  logic         hostCeN,
  input  logic         hostWeN,
  output logic         arrayCeN,
  output logic         arrayWeN,
  output logic         writeInhibit,
  output logic         outHiZ,
  output logic         battSel,
  output logic         battArmed
);

  logic gateOpenQ, inhibitQ, battQ, armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOpenQ <= 1'b0;
      inhibitQ  <= 1'b1;
      battQ     <= 1'b0;
      armedQ    <= 1'b0;
    end else begin
      gateOpenQ <= strobe.allowAccess && (gateOpenQ || hostCeN);
      inhibitQ  <= !strobe.allowAccess;
      battQ     <= strobe.useBattery;
      armedQ    <= armedQ || strobe.breakSeal;
    end
  end

  assign arrayCeN     = gateOpenQ ? hostCeN : 1'b1;
  assign arrayWeN     = gateOpenQ ? hostWeN : 1'b1;
  assign outHiZ       = !gateOpenQ;
  assign writeInhibit = inhibitQ;
  assign battSel      = battQ;
  assign battArmed    = armedQ;

endmodule

// File: rtl/pwr_guard_top.sv
`timescale 1ns/1ps
module pwr_guard_top
  import pwr_guard_pkg::*;
#(
  parameter int RECOVER_TICKS = 125,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CLKS   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic aboveTrip,
  input  logic aboveFull,
  input  logic aboveSwitch,
  input  logic hostCeN,
  input  logic hostWeN,
  output logic arrayCeN,
  output logic arrayWeN,
  output logic writeInhibit,
  output logic outHiZ,
  output logic battSel,
  output logic battArmed
);

  logic [FLAG_W-1:0] rawFlags, filtFlags;
  guardStrobe_t      strobe;

  always_comb begin
    rawFlags              = '0;
    rawFlags[FLAG_TRIP]   = aboveTrip;
    rawFlags[FLAG_FULL]   = aboveFull;
    rawFlags[FLAG_SWITCH] = aboveSwitch;
  end

  pwr_guard_sync #(
    .WIDTH(FLAG_W), .SYNC_STAGES(SYNC_STAGES), .STABLE_CLKS(STABLE_CLKS)
  ) sync_i (
    .clk(clk), .rstN(rstN), .rawFlags(rawFlags), .filtFlags(filtFlags)
  );

  pwr_guard_ctrl #(.RECOVER_TICKS(RECOVER_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .flags(filtFlags), .msTick(msTick), .strobe(strobe)
  );

  pwr_guard_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostCeN(hostCeN), .hostWeN(hostWeN),
    .arrayCeN(arrayCeN), .arrayWeN(arrayWeN),
    .writeInhibit(writeInhibit), .outHiZ(outHiZ),
    .battSel(battSel), .battArmed(battArmed)
  );

endmodule

// File: rtl/pwr_guard_chk.sv
`timescale 1ns/1ps
module pwr_guard_chk (
  input logic clk,
  input logic rstN,
  input logic msTick,
  input logic aboveTrip,
  input logic aboveFull,
  input logic aboveSwitch,
  input logic hostCeN,
  input logic hostWeN,
  input logic arrayCeN,
  input logic arrayWeN,
  input logic writeInhibit,
  input logic outHiZ,
  input logic battSel,
  input logic battArmed
);

  assert_block_when_inhibit_R4: assert property (@(posedge clk) disable iff (!rstN)
    writeInhibit |-> (arrayCeN && arrayWeN && outHiZ));

  assert_no_strobe_when_float_R10: assert property (@(posedge clk) disable iff (!rstN)
    outHiZ |-> (arrayCeN && arrayWeN));

  assert_batt_needs_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    battSel |-> battArmed);

  assert_seal_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    battArmed |=> battArmed);

  assert_batt_protected_R6: assert property (@(posedge clk) disable iff (!rstN)
    battSel |-> writeInhibit);

  assert_open_after_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outHiZ) |-> $past(hostCeN));

  assert_abort_with_protect_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeInhibit) |-> arrayWeN);

endmodule

bind pwr_guard_top pwr_guard_chk chk_i (.*);

// File: tb/pwr_guard_tb.sv
`timescale 1ns/1ps
module pwr_guard_top_tb_top;

  localparam int RT       = 4;
  localparam int TICK_DIV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic aboveTrip = 1'b0, aboveFull = 1'b0, aboveSwitch = 1'b0;
  logic hostCeN = 1'b1, hostWeN = 1'b1;
  logic arrayCeN, arrayWeN, writeInhibit, outHiZ, battSel, battArmed;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pwr_guard_top #(.RECOVER_TICKS(RT)) dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick),
    .aboveTrip(aboveTrip), .aboveFull(aboveFull), .aboveSwitch(aboveSwitch),
    .hostCeN(hostCeN), .hostWeN(hostWeN),
    .arrayCeN(arrayCeN), .arrayWeN(arrayWeN), .writeInhibit(writeInhibit),
    .outHiZ(outHiZ), .battSel(battSel), .battArmed(battArmed)
  );

  // millisecond tick stand-in
  int tickDiv = 0;
  always @(posedge clk) begin
    tickDiv <= (tickDiv == TICK_DIV - 1) ? 0 : tickDiv + 1;
    msTick  <= (tickDiv == TICK_DIV - 1);
  end

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // states: 0 sealed, 1 ok, 2 protected, 3 battery, 4 recovering
  int         mState = 0;
  int         mCnt   = 0;
  logic [2:0] mFilt  = '0;
  logic [2:0] hist[$] = '{3'b0, 3'b0, 3'b0};
  bit         mArmed = 0, mBatt = 0, mInhibit = 1, mGate = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mFilt = '0; hist = '{3'b0, 3'b0, 3'b0};
      mArmed = 0; mBatt = 0; mInhibit = 1; mGate = 0;
    end else begin
      int   nxt;
      logic tr, fu, sw;
      tr = mFilt[0]; fu = mFilt[1]; sw = mFilt[2];
      nxt = mState;
      case (mState)
        0: if (tr) nxt = 4;
        1: if (!sw) nxt = 3; else if (!tr) nxt = 2;
        2: if (!sw) nxt = 3; else if (tr && fu) nxt = 4;
        3: if (sw) nxt = 2;
        4: if (!sw) nxt = 3; else if (!tr) nxt = 2; else if (mCnt == RT && fu) nxt = 1;
        default: nxt = 0;
      endcase
      if (mState == 4 && nxt == 4) begin
        if (msTick && mCnt < RT) mCnt++;
      end else mCnt = 0;
      if (mState == 0 && tr) mArmed = 1;
      mBatt    = (nxt == 3);
      mInhibit = (nxt != 1);
      mGate    = (nxt == 1) && (mGate || hostCeN);
      // filtered flag = value two samples back, if it matched the one before
      if (hist[1] == hist[2]) mFilt = hist[1];
      hist.push_front({aboveSwitch, aboveFull, aboveTrip});
      void'(hist.pop_back());
      mState = nxt;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3",  battArmed,    mArmed,                   "model battArmed");
      check("R6",  battSel,      mBatt,                    "model battSel");
      check("R4",  writeInhibit, mInhibit,                 "model writeInhibit");
      check("R8",  outHiZ,       !mGate,                   "model outHiZ");
      check("R10", arrayCeN,     mGate ? hostCeN : 1'b1,   "model arrayCeN");
      check("R10", arrayWeN,     mGate ? hostWeN : 1'b1,   "model arrayWeN");
    end
  end

  // ---------------- stimulus ----------------
  task automatic setFlags(logic t, logic f, logic s);
    @(posedge clk); #1;
    aboveTrip = t; aboveFull = f; aboveSwitch = s;
  endtask

  task automatic setHost(logic ce, logic we);
    @(posedge clk); #1;
    hostCeN = ce; hostWeN = we;
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1", writeInhibit, 1'b1, "reset writeInhibit");
    check("R1", outHiZ,       1'b1, "reset outHiZ");
    check("R1", battSel,      1'b0, "reset battSel");
    check("R1", battArmed,    1'b0, "reset battArmed");
    check("R1", arrayWeN,     1'b1, "reset arrayWeN");

    // above switchover only: still sealed, battery untouched
    setFlags(0, 0, 1);
    waitNeg(10);
    check("R3", battArmed, 1'b0, "sealed below trip");
    check("R3", battSel,   1'b0, "sealed battSel");

    // power up with host holding CE active
    setHost(0, 1);
    setFlags(1, 1, 1);
    waitNeg(12);
    check("R3", battArmed,    1'b1, "seal broken");
    check("R8", writeInhibit, 1'b1, "still recovering");
    waitNeg(60);
    check("R8", writeInhibit, 1'b0, "recovery finished");
    check("R9", outHiZ,       1'b1, "gate held while CE low");
    setHost(1, 1);
    waitNeg(2);
    check("R9", outHiZ, 1'b0, "gate opened after CE release");

    // pass-through
    setHost(0, 0);
    @(negedge clk);
    check("R10", arrayCeN, 1'b0, "CE passes");
    check("R10", arrayWeN, 1'b0, "WE passes");
    setHost(0, 1);
    @(negedge clk);
    check("R10", arrayWeN, 1'b1, "WE release passes");

    // one-clock glitch on trip flag is ignored
    setFlags(0, 1, 1);
    setFlags(1, 1, 1);
    waitNeg(10);
    check("R2", writeInhibit, 1'b0, "glitch ignored");
    check("R2", arrayCeN,     1'b0, "access kept through glitch");

    // abort a write in progress
    setHost(0, 0);
    setFlags(0, 0, 1);
    begin
      bit seen = 0;
      for (int i = 0; i < 20 && !seen; i++) begin
        @(negedge clk);
        if (writeInhibit) begin
          seen = 1;
          check("R5", arrayWeN, 1'b1, "write cut with protection");
        end
      end
      check("R5", seen, 1'b1, "protection reached");
    end

    // hysteresis: above trip but below full stays protected
    setFlags(1, 0, 1);
    waitNeg(40);
    check("R7", writeInhibit, 1'b1, "below full level");

    // battery switchover and back
    setHost(1, 1);
    setFlags(0, 0, 0);
    waitNeg(8);
    check("R6", battSel,   1'b1, "battery selected");
    check("R3", battArmed, 1'b1, "seal stays broken");
    setFlags(0, 0, 1);
    waitNeg(8);
    check("R6", battSel,      1'b0, "battery released");
    check("R6", writeInhibit, 1'b1, "still protected after switch back");

    // drop during recovery restarts the count
    setFlags(1, 1, 1);
    waitNeg(16);
    setFlags(0, 0, 1);
    repeat (2) @(posedge clk);
    setFlags(1, 1, 1);
    waitNeg(26);
    check("R11", writeInhibit, 1'b1, "recovery restarted");
    waitNeg(40);
    check("R11", writeInhibit, 1'b0, "recovery completed again");
    check("R11", outHiZ,       1'b0, "access restored");

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

endmodule